// File: doc/BRIEF.md
# Loopback Transmit Readback Buffer

This block sits beside a transmit byte stream and keeps a copy of the most recent bytes sent while the controller is in loopback mode. Each byte presented with its valid strobe goes into an eight-entry circular store. The write pointer wraps at the end of the store, so the oldest byte is always the one replaced. When the packet closes, the read pointer is set to the oldest byte still held. A processor can then pull the bytes out in the order they were sent, one per read strobe.

Readback works only while the loopback-mode input is high. A read with loopback off returns zero and leaves the read pointer where it was. Transmit bytes and packet-end strobes are ignored while loopback is off.

A small controller tracks the mode with three states:
- `ST_OFF`: loopback is disabled.
- `ST_FILL`: bytes of a packet are arriving.
- `ST_DRAIN`: the packet has closed and the bytes are ready to read back.

The transitions are:
- *disable*: any state goes to `ST_OFF` when `lpbk_en` is low.
- *enable*: `ST_OFF` goes to `ST_FILL` when loopback is on and no packet end is seen.
- *close*: `ST_FILL` or `ST_OFF` goes to `ST_DRAIN` on an accepted packet end.
- *restart*: `ST_DRAIN` goes to `ST_FILL` on a new byte that carries no end strobe.

Top module: `lpbk_readback_buf`

## Requirements
- R1: After reset, `rd_data` is 0x00 and every store entry is 0x00, so a first read in loopback returns 0x00.
- R2: While `lpbk_en` is high, each cycle with `tx_valid` high writes `tx_byte` at the write pointer. The write pointer then advances modulo 8, so the store holds the last 8 bytes and the oldest byte is the one overwritten.
- R3: An accepted packet end sets the read pointer to the oldest retained byte. Eight reads that follow return the retained bytes in transmit order.
- R4: If fewer than 8 bytes have been written since reset, the packet end points the read pointer at the first byte written.
- R5: The read pointer wraps after the eighth position, so a ninth read returns the same byte as the first.
- R6: A read strobe while `lpbk_en` is low returns 0x00 on `rd_data` in the next cycle and does not move the read pointer.
- R7: `tx_valid` and `tx_end` are ignored while `lpbk_en` is low. The store and both pointers stay unchanged.
- R8: `rd_data` changes only in the cycle after a read strobe and holds its value otherwise.
- R9: When `tx_end` is high together with `tx_valid`, the byte of that cycle belongs to the packet and is the newest retained byte.
- R10: A `tx_end` strobe that arrives in `ST_DRAIN` without a byte is ignored, so the read pointer keeps its position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lpbk_en | input | 1 | Loopback mode enable |
| tx_valid | input | 1 | Transmit byte valid strobe |
| tx_byte | input | 8 | Transmitted data byte |
| tx_end | input | 1 | Packet end strobe |
| rd_stb | input | 1 | Processor read strobe |
| rd_data | output | 8 | Read-back byte, registered |

## Verification
The bench builds the block with its default parameters: an 8-bit data width and a depth of eight. With these values, a single eleven-byte packet pushes the write pointer past a full wrap, so the overwrite of old bytes and the placement of the read pointer at the oldest byte can both be observed. Nine sequential reads are then enough to reach the read-pointer wrap. A three-byte packet sent from reset covers the case where the store is only partly filled.

// File: rtl/lpbk_pkg.sv
package lpbk_pkg;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_FILL  = 2'd1,
        ST_DRAIN = 2'd2
    } lpbk_state_e;

endpackage

// File: rtl/lpbk_ctrl.sv
module lpbk_ctrl
    import lpbk_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        lpbk_en,
    input  logic        tx_valid,
    input  logic        tx_end,
    input  logic        rd_stb,
    output lpbk_state_e state,
    output logic        wr_en,
    output logic        rd_en,
    output logic        end_en
);

    lpbk_state_e state_nxt;
    logic        end_ok;

    // a packet end counts unless the packet is already closed and no byte comes with it
    always_comb begin
        end_ok = lpbk_en && tx_end && ((state != ST_DRAIN) || tx_valid);
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_OFF: begin
                if (!lpbk_en)    state_nxt = ST_OFF;
                else if (end_ok) state_nxt = ST_DRAIN;
                else             state_nxt = ST_FILL;
            end
            ST_FILL: begin
                if (!lpbk_en)    state_nxt = ST_OFF;
                else if (end_ok) state_nxt = ST_DRAIN;
                else             state_nxt = ST_FILL;
            end
            ST_DRAIN: begin
                if (!lpbk_en)      state_nxt = ST_OFF;
                else if (end_ok)   state_nxt = ST_DRAIN;
                else if (tx_valid) state_nxt = ST_FILL;
                else               state_nxt = ST_DRAIN;
            end
            default: state_nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= state_nxt;
    end

    always_comb begin
        wr_en  = lpbk_en && tx_valid;
        rd_en  = lpbk_en && rd_stb;
        end_en = end_ok;
    end

endmodule

// File: rtl/lpbk_ptrs.sv
module lpbk_ptrs #(
    parameter int DEPTH = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          end_en,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] fill_cnt
);

    logic [AW-1:0] wr_ptr_nxt;
    logic [CW-1:0] cnt_nxt;
    logic [AW:0]   back_sum;
    logic [AW-1:0] oldest;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        else                     return p + AW'(1);
    endfunction

    always_comb begin
        wr_ptr_nxt = wr_en ? step(wr_ptr) : wr_ptr;
        if (wr_en && (fill_cnt != CW'(DEPTH))) cnt_nxt = fill_cnt + CW'(1);
        else                                   cnt_nxt = fill_cnt;
    end

    // oldest retained slot: next write slot minus the number of held bytes, modulo DEPTH
    always_comb begin
        back_sum = {1'b0, wr_ptr_nxt} + (AW+1)'(DEPTH) - (AW+1)'(cnt_nxt);
        if (back_sum >= (AW+1)'(DEPTH)) back_sum = back_sum - (AW+1)'(DEPTH);
        oldest = back_sum[AW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            fill_cnt <= '0;
        end else begin
            wr_ptr   <= wr_ptr_nxt;
            fill_cnt <= cnt_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_ptr <= '0;
        else if (end_en) rd_ptr <= oldest;
        else if (rd_en)  rd_ptr <= step(rd_ptr);
    end

endmodule

// File: rtl/lpbk_store.sv
module lpbk_store #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_ptr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_req,
    input  logic              rd_en,
    input  logic [AW-1:0]     rd_ptr,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr_en && (wr_ptr == AW'(g)))
                slot[g] <= wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_data <= '0;
        else if (rd_req) rd_data <= rd_en ? slot[rd_ptr] : '0;
    end

endmodule

// File: rtl/lpbk_readback_buf.sv
module lpbk_readback_buf
    import lpbk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lpbk_en,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_end,
    input  logic              rd_stb,
    output logic [DATA_W-1:0] rd_data
);

    lpbk_state_e   state;
    logic          wr_en;
    logic          rd_en;
    logic          end_en;
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [CW-1:0] fill_cnt;

    lpbk_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .lpbk_en  (lpbk_en),
        .tx_valid (tx_valid),
        .tx_end   (tx_end),
        .rd_stb   (rd_stb),
        .state    (state),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .end_en   (end_en)
    );

    lpbk_ptrs #(.DEPTH(DEPTH)) u_ptrs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .end_en   (end_en),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .fill_cnt (fill_cnt)
    );

    lpbk_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ptr  (wr_ptr),
        .wr_data (tx_byte),
        .rd_req  (rd_stb),
        .rd_en   (rd_en),
        .rd_ptr  (rd_ptr),
        .rd_data (rd_data)
    );

endmodule

// File: rtl/lpbk_readback_buf_chk.sv
module lpbk_readback_buf_chk
    import lpbk_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lpbk_en,
    input logic              tx_valid,
    input logic              tx_end,
    input logic              rd_stb,
    input logic [DATA_W-1:0] rd_data,
    input lpbk_state_e       state,
    input logic [AW-1:0]     wr_ptr,
    input logic [AW-1:0]     rd_ptr,
    input logic [CW-1:0]     fill_cnt
);

    function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
        if (p == AW'(DEPTH - 1)) return '0;
        else                     return p + AW'(1);
    endfunction

    // R6
    read_off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lpbk_en && rd_stb) |=> (rd_data == '0 && $stable(rd_ptr)));

    // R7
    tx_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lpbk_en |=> ($stable(wr_ptr) && $stable(fill_cnt) && state == ST_OFF));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R2
    wr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_en && tx_valid) |=> (wr_ptr == nxt($past(wr_ptr))));

    // R5
    rd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_en && rd_stb && !tx_end) |=> (rd_ptr == nxt($past(rd_ptr))));

    // R9
    close_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_en && tx_end && tx_valid) |=> (state == ST_DRAIN));

    // R10
    dup_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lpbk_en && tx_end && !tx_valid && !rd_stb && state == ST_DRAIN) |=> $stable(rd_ptr));

    // R2
    always @(posedge clk) begin
        if (rst_n) begin
            fill_bound_chk: assert (fill_cnt <= CW'(DEPTH));
        end
    end

endmodule

bind lpbk_readback_buf lpbk_readback_buf_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lpbk_en  (lpbk_en),
    .tx_valid (tx_valid),
    .tx_end   (tx_end),
    .rd_stb   (rd_stb),
    .rd_data  (rd_data),
    .state    (state),
    .wr_ptr   (wr_ptr),
    .rd_ptr   (rd_ptr),
    .fill_cnt (fill_cnt)
);

// File: tb/lpbk_readback_buf_test.sv
`timescale 1ns/1ps
module lpbk_readback_buf_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lpbk_en = 1'b0;
    logic       tx_valid = 1'b0;
    logic [7:0] tx_byte = '0;
    logic       tx_end = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    lpbk_readback_buf uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lpbk_en  (lpbk_en),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_end   (tx_end),
        .rd_stb   (rd_stb),
        .rd_data  (rd_data)
    );

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b, input logic last);
        @(negedge clk);
        tx_valid = 1'b1; tx_byte = b; tx_end = last;
        @(negedge clk);
        tx_valid = 1'b0; tx_end = 1'b0;
    endtask

    task automatic end_only();
        @(negedge clk);
        tx_end = 1'b1;
        @(negedge clk);
        tx_end = 1'b0;
    endtask

    task automatic read(output logic [7:0] v);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        check(rd_data, 8'h00, "R1 rd_data after reset");
        lpbk_en = 1'b1;
        read(v);
        check(v, 8'h00, "R1 first read of cleared store");
    endtask

    task automatic t_short_packet();
        logic [7:0] v;
        send(8'hA1, 1'b0);
        send(8'hA2, 1'b0);
        send(8'hA3, 1'b1);
        read(v); check(v, 8'hA1, "R4 short packet first byte");
        read(v); check(v, 8'hA2, "R4 short packet second byte");
        read(v); check(v, 8'hA3, "R9 end with byte keeps last byte");
    endtask

    task automatic t_long_packet();
        logic [7:0] v;
        for (int i = 0; i < 11; i++) send(8'hB0 + 8'(i), i == 10);
        for (int i = 3; i < 11; i++) begin
            read(v);
            check(v, 8'hB0 + 8'(i), "R2 R3 last eight in order");
        end
        read(v); check(v, 8'hB3, "R5 ninth read wraps to oldest");
    endtask

    task automatic t_loop_off();
        logic [7:0] v;
        lpbk_en = 1'b0;
        read(v); check(v, 8'h00, "R6 read outside loopback");
        repeat (3) @(negedge clk);
        check(rd_data, 8'h00, "R8 rd_data holds while idle");
        for (int i = 0; i < 4; i++) send(8'hC0 + 8'(i), i == 3);
        lpbk_en = 1'b1;
        read(v); check(v, 8'hB4, "R6 R7 pointer and store unchanged");
        repeat (2) @(negedge clk);
        check(rd_data, 8'hB4, "R8 rd_data holds after read");
    endtask

    task automatic t_separate_end();
        logic [7:0] v;
        for (int i = 0; i < 8; i++) send(8'hD0 + 8'(i), 1'b0);
        end_only();
        read(v); check(v, 8'hD0, "R3 separate end strobe oldest");
        read(v); check(v, 8'hD1, "R3 second byte");
        end_only();
        read(v); check(v, 8'hD2, "R10 repeated end ignored");
        send(8'hE0, 1'b1);
        read(v); check(v, 8'hD1, "R2 oldest overwritten by new byte");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_packet();
        t_long_packet();
        t_loop_off();
        t_separate_end();
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule